// File: doc/BRIEF.md
# Programmable Up/Down Counter Core with Command Decoder

This block is one channel of a programmable event counter. An external front end supplies a one-cycle count pulse and a direction bit. The core keeps a 24-bit counter, a 24-bit preset register, a 24-bit output latch, an 8-bit clock-prescaler value and five status flags: carry, borrow, compare, sign and error. Software-side logic programs the core with byte-wide command writes. Bits 6:5 of each command byte pick the target register. A second byte port fills the preset one byte at a time, low byte first.

A reset/load command can do several things in a single write: it clears the counter, the flags or the error bit, rewinds the preset byte pointer, and moves the preset into the counter, the counter into the output latch, or the preset low byte into the prescaler. A mode command picks binary or BCD counting and one of four limit behaviours: free-running, range-limit, non-recycle and modulo-N. A write reaches the channel when its select line is high, or when bit 7 of the byte is set. Bit 7 is the broadcast bit, which lets one write program every channel at once.

The limit behaviour runs on a four-state machine. RUN is the normal counting state. AT_TOP means an up-count has been frozen at the preset. AT_BOTTOM means a down-count has been frozen at zero. HALTED means counting has stopped after a wrap in non-recycle mode. The transitions are:
- RUN to AT_TOP: in range-limit mode, an up pulse arrives while the count equals the preset.
- RUN to AT_BOTTOM: in range-limit mode, a down pulse arrives at zero.
- RUN to HALTED: in non-recycle mode, a step wraps the count.
- AT_TOP or AT_BOTTOM back to RUN: a pulse arrives in the opposite direction.
- Any state to RUN (the reload transition): a counter clear, a preset transfer or a mode write.

Top module: `cmd_counter`

## Requirements
- R1: After reset the counter, preset, output latch, prescaler and all five flags are zero, the mode is binary free-running, and the byte pointer addresses the low preset byte.
- R2: Each preset data write stores its byte at the pointer (byte 0 = bits 7:0) and advances the pointer 0,1,2,0. Bit 0 of a reset/load command (bits 6:5 = 00) returns the pointer to byte 0.
- R3: In a reset/load command, bits 2:1 have these effects: 01 clears the counter, 10 clears the carry, borrow, compare and sign flags, 11 clears the error flag.
- R4: In a reset/load command, bits 4:3 have these effects: 01 copies the preset into the counter, and this wins over a clear in the same byte; 10 copies the count held before the write into the latch; 11 copies preset bits 7:0 into the prescaler.
- R5: A command with bits 6:5 = 01 sets BCD counting from bit 0 and the limit behaviour from bits 2:1 (00 free, 01 range-limit, 10 non-recycle, 11 modulo-N). A command with bits 6:5 = 10 or 11 changes nothing in this core.
- R6: A command write takes effect only when the select input is high or bit 7 of the byte is set.
- R7: In free-running mode an up pulse (step_up = 1) adds one and a down pulse subtracts one. An up wrap from the maximum (FFFFFF binary, 999999 BCD) to zero sets carry and clears sign. A down wrap from zero to the maximum sets borrow and sets sign.
- R8: In BCD mode each 4-bit digit rolls over from 9 to 0. A count pulse while any digit is above 9 leaves the count unchanged and sets the error flag.
- R9: In range-limit mode, an up pulse at count == preset holds the count, sets carry and freezes further up pulses. A down pulse at zero holds the count, sets borrow and freezes further down pulses. A pulse in the opposite direction resumes counting.
- R10: In non-recycle mode the step that wraps is applied and sets carry or borrow. All later pulses are ignored until a counter clear, a preset transfer or a mode write.
- R11: In modulo-N mode, an up pulse at count == preset loads zero and sets carry. A down pulse at zero loads the preset and sets borrow.
- R12: The compare flag is set whenever an applied step leaves the count equal to the preset.
- R13: A count pulse in the same cycle as an accepted reset/load or mode command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_sel | input | 1 | Channel select for the command write |
| cmd_byte | input | 8 | Command byte |
| pre_we | input | 1 | Preset data byte strobe |
| pre_byte | input | 8 | Preset data byte |
| step_en | input | 1 | One-cycle count pulse |
| step_up | input | 1 | Direction: 1 up, 0 down |
| count_o | output | 24 | Counter value |
| latch_o | output | 24 | Output latch |
| prescale_o | output | 8 | Prescaler load value |
| carry_o | output | 1 | Carry flag |
| borrow_o | output | 1 | Borrow flag |
| compare_o | output | 1 | Compare flag |
| sign_o | output | 1 | Sign flag |
| error_o | output | 1 | Error flag |

## Verification
The bench aims at the wrap points FFFFFF/000000 and 999999/000000. A wrong maximum would wrap early or never raise carry. It also aims at the range-limit edges, where a design that forgets the freeze state would count past the preset or would refuse to reverse. It checks non-recycle halting, where a broken reload transition leaves the counter stuck. It covers commands whose bits combine, such as clear plus transfer and clear plus latch, where the wrong priority would load zero or latch the new count. It also drives count pulses in the same cycle as commands, and writes with neither select nor broadcast, which a faulty decoder would accept.

// File: rtl/cmd_counter_pkg.sv
package cmd_counter_pkg;

    typedef enum logic [1:0] {
        LIM_FREE  = 2'b00,
        LIM_RANGE = 2'b01,
        LIM_NOREC = 2'b10,
        LIM_MODN  = 2'b11
    } limit_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_AT_TOP,
        ST_AT_BOTTOM,
        ST_HALTED
    } run_state_e;

    localparam logic [1:0] SEL_CTRL = 2'b00;
    localparam logic [1:0] SEL_MODE = 2'b01;

    typedef struct packed {
        logic ptr_rst;
        logic cnt_clr;
        logic flag_clr;
        logic err_clr;
        logic pre_xfer;
        logic latch_ld;
        logic psc_ld;
        logic mode_wr;
    } cmd_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmd_counter_pkg::*;
(
    input  logic       wr_en,
    input  logic       sel,
    input  logic [7:0] wr_byte,
    output cmd_t       cmd,
    output logic       busy
);
    logic accept;
    logic ctrl_hit;

    always_comb begin
        accept   = wr_en && (sel || wr_byte[7]);
        ctrl_hit = accept && (wr_byte[6:5] == SEL_CTRL);

        cmd.ptr_rst  = ctrl_hit && wr_byte[0];
        cmd.cnt_clr  = ctrl_hit && (wr_byte[2:1] == 2'b01);
        cmd.flag_clr = ctrl_hit && (wr_byte[2:1] == 2'b10);
        cmd.err_clr  = ctrl_hit && (wr_byte[2:1] == 2'b11);
        cmd.pre_xfer = ctrl_hit && (wr_byte[4:3] == 2'b01);
        cmd.latch_ld = ctrl_hit && (wr_byte[4:3] == 2'b10);
        cmd.psc_ld   = ctrl_hit && (wr_byte[4:3] == 2'b11);
        cmd.mode_wr  = accept && (wr_byte[6:5] == SEL_MODE);

        busy = ctrl_hit || cmd.mode_wr;
    end
endmodule

// File: rtl/preset_reg.sv
module preset_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [7:0]   wr_byte,
    input  logic         ptr_rst,
    output logic [W-1:0] preset
);
    localparam int NB = W / 8;
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_rst) begin
            ptr_q <= '0;
        end else if (we) begin
            ptr_q <= (ptr_q == PW'(NB - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                preset[8*b +: 8] <= 8'h00;
            end else if (we && (ptr_q == PW'(b))) begin
                preset[8*b +: 8] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/step_unit.sv
module step_unit #(
    parameter int W = 24
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] inc,
    output logic [W-1:0] dec,
    output logic         at_max,
    output logic         at_zero,
    output logic         bad
);
    localparam int DIG = W / 4;

    logic [DIG-1:0] eq9, eq0, bad_v;
    logic [W-1:0]   bcd_inc, bcd_dec;

    for (genvar i = 0; i < DIG; i++) begin : g_dig
        logic [3:0] d;
        logic       lo9, lo0;
        assign d        = val[4*i +: 4];
        assign eq9[i]   = (d == 4'd9);
        assign eq0[i]   = (d == 4'd0);
        assign bad_v[i] = (d > 4'd9);
        if (i == 0) begin : g_first
            assign lo9 = 1'b1;
            assign lo0 = 1'b1;
        end else begin : g_rest
            assign lo9 = &eq9[i-1:0];
            assign lo0 = &eq0[i-1:0];
        end
        assign bcd_inc[4*i +: 4] = lo9 ? (eq9[i] ? 4'd0 : d + 4'd1) : d;
        assign bcd_dec[4*i +: 4] = lo0 ? (eq0[i] ? 4'd9 : d - 4'd1) : d;
    end

    always_comb begin
        inc     = bcd ? bcd_inc : val + 1'b1;
        dec     = bcd ? bcd_dec : val - 1'b1;
        at_max  = bcd ? (&eq9) : (&val);
        at_zero = (val == '0);
        bad     = bcd && (|bad_v);
    end
endmodule

// File: rtl/cmd_counter.sv
module cmd_counter
    import cmd_counter_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_we,
    input  logic         cmd_sel,
    input  logic [7:0]   cmd_byte,
    input  logic         pre_we,
    input  logic [7:0]   pre_byte,
    input  logic         step_en,
    input  logic         step_up,
    output logic [W-1:0] count_o,
    output logic [W-1:0] latch_o,
    output logic [7:0]   prescale_o,
    output logic         carry_o,
    output logic         borrow_o,
    output logic         compare_o,
    output logic         sign_o,
    output logic         error_o
);
    cmd_t         cmd;
    logic         busy;
    logic [W-1:0] preset;
    logic [W-1:0] inc_v, dec_v;
    logic         at_max, at_zero, bad;

    run_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         bcd_q;
    limit_e       lim_q;

    // result of a step as if taken from RUN
    logic [W-1:0] run_cnt;
    run_state_e   run_st;
    logic         run_c, run_b;
    // per-cycle events
    logic         ev_c, ev_b, ev_cmp, ev_err;

    cmd_decode u_dec (
        .wr_en   (cmd_we),
        .sel     (cmd_sel),
        .wr_byte (cmd_byte),
        .cmd     (cmd),
        .busy    (busy)
    );

    preset_reg #(.W(W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pre_we),
        .wr_byte (pre_byte),
        .ptr_rst (cmd.ptr_rst),
        .preset  (preset)
    );

    step_unit #(.W(W)) u_step (
        .val     (cnt_q),
        .bcd     (bcd_q),
        .inc     (inc_v),
        .dec     (dec_v),
        .at_max  (at_max),
        .at_zero (at_zero),
        .bad     (bad)
    );

    // Step outcome from the RUN state for the selected limit behaviour
    always_comb begin
        run_cnt = cnt_q;
        run_st  = ST_RUN;
        run_c   = 1'b0;
        run_b   = 1'b0;
        if (step_up) begin
            unique case (lim_q)
                LIM_RANGE: begin
                    if (cnt_q == preset) begin
                        run_st = ST_AT_TOP;
                        run_c  = 1'b1;
                    end else begin
                        run_cnt = inc_v;
                        run_c   = at_max;
                    end
                end
                LIM_MODN: begin
                    if (cnt_q == preset) begin
                        run_cnt = '0;
                        run_c   = 1'b1;
                    end else begin
                        run_cnt = inc_v;
                        run_c   = at_max;
                    end
                end
                LIM_NOREC: begin
                    run_cnt = inc_v;
                    run_c   = at_max;
                    if (at_max) run_st = ST_HALTED;
                end
                LIM_FREE: begin
                    run_cnt = inc_v;
                    run_c   = at_max;
                end
            endcase
        end else begin
            unique case (lim_q)
                LIM_RANGE: begin
                    if (at_zero) begin
                        run_st = ST_AT_BOTTOM;
                        run_b  = 1'b1;
                    end else begin
                        run_cnt = dec_v;
                    end
                end
                LIM_MODN: begin
                    run_cnt = at_zero ? preset : dec_v;
                    run_b   = at_zero;
                end
                LIM_NOREC: begin
                    run_cnt = dec_v;
                    run_b   = at_zero;
                    if (at_zero) run_st = ST_HALTED;
                end
                LIM_FREE: begin
                    run_cnt = dec_v;
                    run_b   = at_zero;
                end
            endcase
        end
    end

    // Next state and counter value
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ev_c    = 1'b0;
        ev_b    = 1'b0;
        ev_cmp  = 1'b0;
        ev_err  = 1'b0;
        if (cmd.cnt_clr || cmd.pre_xfer || cmd.mode_wr) begin
            state_d = ST_RUN;
            if (cmd.pre_xfer)     cnt_d = preset;
            else if (cmd.cnt_clr) cnt_d = '0;
        end else if (step_en && !busy) begin
            if (bad) begin
                ev_err = 1'b1;
            end else begin
                unique case (state_q)
                    ST_RUN: begin
                        state_d = run_st;
                        cnt_d   = run_cnt;
                        ev_c    = run_c;
                        ev_b    = run_b;
                        ev_cmp  = (run_cnt == preset);
                    end
                    ST_AT_TOP: begin
                        if (!step_up) begin
                            state_d = run_st;
                            cnt_d   = run_cnt;
                            ev_c    = run_c;
                            ev_b    = run_b;
                            ev_cmp  = (run_cnt == preset);
                        end
                    end
                    ST_AT_BOTTOM: begin
                        if (step_up) begin
                            state_d = run_st;
                            cnt_d   = run_cnt;
                            ev_c    = run_c;
                            ev_b    = run_b;
                            ev_cmp  = (run_cnt == preset);
                        end
                    end
                    ST_HALTED: begin
                        state_d = ST_HALTED;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Datapath and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            latch_o    <= '0;
            prescale_o <= 8'h00;
            bcd_q      <= 1'b0;
            lim_q      <= LIM_FREE;
            carry_o    <= 1'b0;
            borrow_o   <= 1'b0;
            compare_o  <= 1'b0;
            sign_o     <= 1'b0;
            error_o    <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cmd.latch_ld) latch_o    <= cnt_q;
            if (cmd.psc_ld)   prescale_o <= preset[7:0];
            if (cmd.mode_wr) begin
                bcd_q <= cmd_byte[0];
                lim_q <= limit_e'(cmd_byte[2:1]);
            end
            if (cmd.flag_clr) begin
                carry_o   <= 1'b0;
                borrow_o  <= 1'b0;
                compare_o <= 1'b0;
                sign_o    <= 1'b0;
            end else begin
                if (ev_c)   carry_o   <= 1'b1;
                if (ev_b)   borrow_o  <= 1'b1;
                if (ev_cmp) compare_o <= 1'b1;
                if (ev_b)      sign_o <= 1'b1;
                else if (ev_c) sign_o <= 1'b0;
            end
            if (cmd.err_clr)  error_o <= 1'b0;
            else if (ev_err)  error_o <= 1'b1;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/cmd_counter_chk.sv
module cmd_counter_chk
    import cmd_counter_pkg::*;
#(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic         step_up,
    input logic         busy,
    input run_state_e   state,
    input logic [W-1:0] cnt,
    input logic [W-1:0] latch,
    input logic [W-1:0] preset,
    input logic         latch_cmd,
    input logic         xfer_cmd,
    input logic         errclr_cmd,
    input logic         carry,
    input logic         error
);
    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && !busy) |=> $stable(cnt));

    // R9
    range_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AT_TOP && step_en && step_up && !busy) |=> $stable(cnt));

    // R4
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_cmd |=> (latch == $past(cnt)));

    // R4
    preset_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cmd |=> (cnt == $past(preset)));

    // R3
    error_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        errclr_cmd |=> !error);

    // R7
    carry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry) |-> ($past(step_en) && !$past(busy)));
endmodule

bind cmd_counter cmd_counter_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .step_up    (step_up),
    .busy       (busy),
    .state      (state_q),
    .cnt        (cnt_q),
    .latch      (latch_o),
    .preset     (preset),
    .latch_cmd  (cmd.latch_ld),
    .xfer_cmd   (cmd.pre_xfer),
    .errclr_cmd (cmd.err_clr),
    .carry      (carry_o),
    .error      (error_o)
);

// File: tb/cmd_counter_test.sv
module cmd_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0, cmd_sel = 1'b0, pre_we = 1'b0;
    logic        step_en = 1'b0, step_up = 1'b0;
    logic [7:0]  cmd_byte = 8'h00, pre_byte = 8'h00;
    logic [23:0] count_o, latch_o;
    logic [7:0]  prescale_o;
    logic        carry_o, borrow_o, compare_o, sign_o, error_o;

    always #2 clk = ~clk;

    cmd_counter uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .cmd_byte(cmd_byte), .pre_we(pre_we), .pre_byte(pre_byte),
        .step_en(step_en), .step_up(step_up), .count_o(count_o),
        .latch_o(latch_o), .prescale_o(prescale_o), .carry_o(carry_o),
        .borrow_o(borrow_o), .compare_o(compare_o), .sign_o(sign_o),
        .error_o(error_o)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state (0 run, 1 top, 2 bottom, 3 halted)
    logic [23:0] m_cnt = 0, m_pre = 0, m_latch = 0;
    logic [7:0]  m_psc = 0;
    int          m_ptr = 0, m_st = 0;
    logic        m_bcd = 0;
    logic [1:0]  m_lim = 0;
    logic        m_c = 0, m_b = 0, m_cmp = 0, m_s = 0, m_e = 0;

    function automatic int to_int(logic [23:0] v);
        int r = 0;
        for (int i = 5; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [23:0] from_int(int n);
        logic [23:0] r = 0;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(n % 10);
            n = n / 10;
        end
        return r;
    endfunction

    function automatic bit digits_ok(logic [23:0] v);
        for (int i = 0; i < 6; i++) if (v[4*i +: 4] > 4'd9) return 0;
        return 1;
    endfunction

    function automatic logic [23:0] m_inc(logic [23:0] v);
        return m_bcd ? from_int((to_int(v) + 1) % 1000000) : v + 24'd1;
    endfunction

    function automatic logic [23:0] m_dec(logic [23:0] v);
        return m_bcd ? from_int((to_int(v) + 999999) % 1000000) : v - 24'd1;
    endfunction

    task automatic m_step(logic up);
        logic [23:0] maxv;
        logic c = 0, b = 0;
        maxv = m_bcd ? 24'h999999 : 24'hFFFFFF;
        if (m_bcd && !digits_ok(m_cnt)) begin m_e = 1; return; end
        if (m_st == 3) return;
        if (m_st == 1 && up) return;
        if (m_st == 2 && !up) return;
        m_st = 0;
        if (up) begin
            if ((m_lim == 2'b01) && m_cnt == m_pre) begin m_st = 1; c = 1; end
            else if ((m_lim == 2'b11) && m_cnt == m_pre) begin m_cnt = 0; c = 1; end
            else begin
                c = (m_cnt == maxv);
                m_cnt = m_inc(m_cnt);
                if (m_lim == 2'b10 && c) m_st = 3;
            end
        end else begin
            if ((m_lim == 2'b01) && m_cnt == 0) begin m_st = 2; b = 1; end
            else if ((m_lim == 2'b11) && m_cnt == 0) begin m_cnt = m_pre; b = 1; end
            else begin
                b = (m_cnt == 0);
                m_cnt = m_dec(m_cnt);
                if (m_lim == 2'b10 && b) m_st = 3;
            end
        end
        if (c) begin m_c = 1; m_s = 0; end
        if (b) begin m_b = 1; m_s = 1; end
        if (m_cnt == m_pre) m_cmp = 1;
    endtask

    task automatic m_cmd(logic [7:0] v, logic s);
        logic [23:0] old;
        if (!(s || v[7])) return;
        old = m_cnt;
        if (v[6:5] == 2'b00) begin
            if (v[0]) m_ptr = 0;
            case (v[2:1])
                2'b01: begin m_cnt = 0; m_st = 0; end
                2'b10: begin m_c = 0; m_b = 0; m_cmp = 0; m_s = 0; end
                2'b11: m_e = 0;
                default: ;
            endcase
            case (v[4:3])
                2'b01: begin m_cnt = m_pre; m_st = 0; end
                2'b10: m_latch = old;
                2'b11: m_psc = m_pre[7:0];
                default: ;
            endcase
        end else if (v[6:5] == 2'b01) begin
            m_bcd = v[0];
            m_lim = v[2:1];
            m_st  = 0;
        end
    endtask

    task automatic m_data(logic [7:0] v);
        m_pre[8*m_ptr +: 8] = v;
        m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
    endtask

    task automatic check(string tag);
        logic [60:0] act, exp;
        act = {count_o, latch_o, prescale_o, carry_o, borrow_o, compare_o, sign_o, error_o};
        exp = {m_cnt, m_latch, m_psc, m_c, m_b, m_cmp, m_s, m_e};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cnt,latch,psc,c,b,cmp,s,e)", tag, act, exp);
        end
    endtask

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(bit cw, logic [7:0] cb, bit cs, bit pw, logic [7:0] pb,
                         bit se, bit su);
        bit busy;
        @(negedge clk);
        cmd_we = cw; cmd_byte = cb; cmd_sel = cs;
        pre_we = pw; pre_byte = pb; step_en = se; step_up = su;
        @(posedge clk);
        #1;
        cmd_we = 0; pre_we = 0; step_en = 0; cmd_sel = 0;
        busy = cw && (cs || cb[7]) && !cb[6];
        if (cw) m_cmd(cb, cs);
        if (se && !busy) m_step(su);
        if (pw) m_data(pb);
    endtask

    task automatic cmd(logic [7:0] v);  drive(1, v, 1, 0, 0, 0, 0); endtask
    task automatic data(logic [7:0] v); drive(0, 0, 0, 1, v, 0, 0); endtask
    task automatic step(bit up);        drive(0, 0, 0, 0, 0, 1, up); endtask

    task automatic load(logic [23:0] v);
        cmd(8'h01);
        data(v[7:0]); data(v[15:8]); data(v[23:16]);
        cmd(8'h08);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 reset state");

        // R2 byte order and pointer rewind
        data(8'h56); data(8'h34); data(8'h12); cmd(8'h08);
        check_val("R2 byte order", count_o, 24'h123456);
        data(8'hAA); cmd(8'h01); data(8'h77); cmd(8'h08);
        check_val("R2 pointer rewind", count_o, 24'h123477);

        // R4 latch, prescaler, combined bits
        cmd(8'h10); check_val("R4 latch", latch_o, 24'h123477);
        cmd(8'h18); check_val("R4 prescaler", prescale_o, 8'h77);
        step(1); cmd(8'h12);
        check_val("R4 latch old count", latch_o, 24'h123478);
        check_val("R3 counter clear", count_o, 0);
        cmd(8'h0A); check_val("R4 transfer wins", count_o, 24'h123477);

        // R6 select/broadcast
        drive(1, 8'h02, 0, 0, 0, 0, 0);
        check_val("R6 unselected ignored", count_o, 24'h123477);
        drive(1, 8'h82, 0, 0, 0, 0, 0);
        check_val("R6 broadcast accepted", count_o, 0);

        // R7 binary wrap
        load(24'hFFFFFF); step(1);
        check_val("R7 up wrap", {count_o, carry_o, sign_o}, {24'h0, 1'b1, 1'b0});
        step(0);
        check_val("R7 down wrap", {count_o, borrow_o, sign_o}, {24'hFFFFFF, 1'b1, 1'b1});
        cmd(8'h04); check("R3 flag clear");

        // R5 IO-control write changes nothing, mode write to BCD
        cmd(8'h47); cmd(8'h5F); check("R5 ignored selector");
        cmd(8'h21);
        load(24'h000099); step(1);
        check_val("R8 digit roll", count_o, 24'h000100);
        load(24'h999999); step(1);
        check_val("R7 BCD wrap", {count_o, carry_o}, {24'h0, 1'b1});
        load(24'h00000A); step(1);
        check_val("R8 invalid digit", {count_o, error_o}, {24'h00000A, 1'b1});
        cmd(8'h06); check_val("R3 error clear", error_o, 0);

        // R9 range limit
        cmd(8'h22); load(24'h3); cmd(8'h02);
        for (int i = 0; i < 5; i++) step(1);
        check_val("R9 freeze at preset", {count_o, carry_o}, {24'h3, 1'b1});
        check_val("R12 compare", compare_o, 1);
        step(0); check_val("R9 reverse", count_o, 24'h2);
        cmd(8'h02); step(0); step(0);
        check_val("R9 freeze at zero", {count_o, borrow_o}, {24'h0, 1'b1});

        // R10 non-recycle
        cmd(8'h24); load(24'hFFFFFE); step(1); step(1); step(1); step(0);
        check_val("R10 halted", count_o, 0);
        cmd(8'h08); step(1);
        check_val("R10 reload resumes", count_o, 24'hFFFFFF);

        // R11 modulo-N
        cmd(8'h26); load(24'h2); cmd(8'h02);
        step(1); step(1); step(1);
        check_val("R11 up wrap to zero", {count_o, carry_o}, {24'h0, 1'b1});
        step(0); check_val("R11 down reload", {count_o, borrow_o}, {24'h2, 1'b1});

        // R13 collision
        drive(1, 8'h20, 1, 0, 0, 1, 1);
        check_val("R13 step dropped", count_o, 24'h2);
        drive(1, 8'h40, 1, 0, 0, 1, 1);
        check_val("R13 IO write no block", count_o, 24'h3);
        check("R12 model agreement");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 5) begin
                logic [23:0] v;
                case ($urandom % 4)
                    0: v = 24'hFFFFFD;
                    1: v = 24'h999997;
                    2: v = 24'h000002;
                    default: v = 24'($urandom);
                endcase
                load(v);
                check("R4 random load");
            end else if (r < 15) begin
                logic [7:0] b;
                b = 8'($urandom);
                drive(1, b, ($urandom % 4) != 0, 0, 0, ($urandom % 2), ($urandom % 2));
                check("R13 random command");
            end else if (r < 20) begin
                data(8'($urandom));
                check("R2 random data");
            end else begin
                step($urandom % 2);
                case (m_lim)
                    2'b00: check("R7 random step");
                    2'b01: check("R9 random step");
                    2'b10: check("R10 random step");
                    default: check("R11 random step");
                endcase
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule